// File: doc/BRIEF.md
# TLB Maintenance Engine

This block owns the entry array of a fully associative translation buffer and carries out the three operations that change it. A **map** operation installs a new translation in a slot picked by a search. The search takes the lowest-numbered empty slot first. If no slot is empty, it takes the lowest-numbered slot that is not pinned. A **direct** operation writes one slot chosen by address bits, and it ignores pinning. A **demap** operation removes every live translation whose page covers a given virtual address. Each slot uses its own page size for that comparison.

Whenever a live translation is overwritten or removed, the engine raises a one-cycle flush request. The request gives the page base and the byte size of the translation that disappeared, so that any cached copy of it elsewhere can be discarded. The tag of a newly installed translation always comes from the tag-access input. The translation word comes from the operation data.

A demap walks the array one slot per cycle. While it runs, the engine reports busy and ignores new operations. A combinational read port exposes any slot's tag and translation word.

Top module: `tlb_maint_engine`

## Requirements
- R1: After reset every slot holds tag 0 and translation word 0, and `busy_o`, `no_slot_o` and `flush_valid_o` are low.
- R2: A map operation (`op_kind` = 0) writes the lowest-index slot whose translation word has bit 63 (live) clear. It does so even when a lower-index live slot is unpinned.
- R3: If no slot is empty, a map operation writes the lowest-index slot whose translation word has bit 6 (pin) clear.
- R4: If every slot is live and pinned, a map operation changes no slot and raises no flush. `no_slot_o` is high for exactly the one cycle after the operation is accepted.
- R5: A direct operation (`op_kind` = 1) writes the slot indexed by `op_addr[8:3]`, whether or not that slot is pinned.
- R6: A written slot takes its tag from `tag_access_i` and its translation word from `op_data`. The new contents are visible on the read port in the cycle after acceptance.
- R7: When a write or demap replaces a slot whose old word had bit 63 set, `flush_valid_o` is high for the one cycle after that update. In that cycle `flush_base_o` equals old tag AND mask, and `flush_size_o` equals 2^(13+3·s), where s is old word bits 62:61 and mask is all ones shifted left by 13+3·s. Replacing an empty slot raises no flush.
- R8: A demap operation (`op_kind` = 2, address on `op_addr`) holds `busy_o` high for exactly 64 cycles. It zeroes the tag and word of each live slot whose tag, masked by that slot's own mask, equals the masked demap address. Non-matching and empty slots keep their contents.
- R9: While `busy_o` is high, incoming operations are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | 0 map, 1 direct, 2 demap, 3 none |
| op_addr | input | 64 | Direct index in bits 8:3; demap virtual address |
| op_data | input | 64 | New translation word |
| tag_access_i | input | 64 | Tag for the slot being written |
| rd_idx | input | 6 | Read-port slot index |
| rd_tag_o | output | 64 | Tag of slot `rd_idx` |
| rd_tte_o | output | 64 | Translation word of slot `rd_idx` |
| busy_o | output | 1 | Demap walk in progress |
| no_slot_o | output | 1 | Previous map operation was dropped |
| flush_valid_o | output | 1 | Flush request |
| flush_base_o | output | 64 | Base of the evicted page |
| flush_size_o | output | 64 | Byte size of the evicted page |

## Verification
A wrong victim choice appears on the read port in the cycle after the map operation. A slot gets overwritten that should have kept its contents, and if the slot was live, the flush base reveals which slot was hit in that same cycle. A demap walker that skips a slot, stops early or uses the wrong mask shows up in three ways when the walk ends: a busy window that is not 64 cycles long, a wrong count of flush pulses, or a slot that still holds a page it should have lost. A wrong size decode shows up at once as a mis-sized or misaligned flush.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int WORD_W     = 64;
    localparam int LIVE_POS   = 63;
    localparam int PIN_POS    = 6;
    localparam int SZ_LSB     = 61;
    localparam int PAGE_SHIFT = 13;
    localparam int SZ_STEP    = 3;
    localparam int IDX_LSB    = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_MAP    = 2'd0,
        OP_DIRECT = 2'd1,
        OP_DEMAP  = 2'd2,
        OP_NONE   = 2'd3
    } op_kind_e;

    typedef struct packed {
        word_t tag;
        word_t tte;
    } entry_t;

    typedef struct packed {
        logic  valid;
        word_t base;
        word_t size;
    } flush_t;

    function automatic logic is_live(word_t tte);
        return tte[LIVE_POS];
    endfunction

    function automatic logic is_pinned(word_t tte);
        return tte[PIN_POS];
    endfunction

    // Mask of the virtual-page bits for the page size encoded in the word.
    function automatic word_t page_mask(word_t tte);
        logic [1:0] code;
        code = tte[SZ_LSB +: 2];
        return {WORD_W{1'b1}} << (PAGE_SHIFT + SZ_STEP * int'(code));
    endfunction

endpackage

// File: rtl/tlbm_victim_pick.sv
module tlbm_victim_pick #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] live_vec,
    input  logic [N_ENTRIES-1:0] pin_vec,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o
);
    logic [N_ENTRIES-1:0] empty_vec;
    logic [N_ENTRIES-1:0] free_vec;
    logic                 empty_found;
    logic                 free_found;
    logic [IDX_W-1:0]     empty_idx;
    logic [IDX_W-1:0]     free_idx;

    assign empty_vec = ~live_vec;
    assign free_vec  = ~pin_vec;

    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        empty_found = 1'b0;
        empty_idx   = '0;
        free_found  = 1'b0;
        free_idx    = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (empty_vec[i]) begin
                empty_found = 1'b1;
                empty_idx   = IDX_W'(i);
            end
            if (free_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign found_o = empty_found | free_found;
    assign idx_o   = empty_found ? empty_idx : free_idx;

endmodule

// File: rtl/tlbm_demap_walker.sv
module tlbm_demap_walker #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] ptr_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            ptr_o  <= '0;
        end else if (busy_o) begin
            if (ptr_o == LAST) begin
                busy_o <= 1'b0;
                ptr_o  <= '0;
            end else begin
                ptr_o <= ptr_o + 1'b1;
            end
        end else if (start_i) begin
            busy_o <= 1'b1;
            ptr_o  <= '0;
        end
    end

endmodule

// File: rtl/tlb_maint_engine.sv
module tlb_maint_engine
    import tlbm_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [WORD_W-1:0] op_addr,
    input  logic [WORD_W-1:0] op_data,
    input  logic [WORD_W-1:0] tag_access_i,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_tag_o,
    output logic [WORD_W-1:0] rd_tte_o,
    output logic              busy_o,
    output logic              no_slot_o,
    output logic              flush_valid_o,
    output logic [WORD_W-1:0] flush_base_o,
    output logic [WORD_W-1:0] flush_size_o
);
    entry_t               ent_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] live_vec;
    logic [N_ENTRIES-1:0] pin_vec;
    logic                 vict_found;
    logic [IDX_W-1:0]     vict_idx;
    logic                 walk_busy;
    logic [IDX_W-1:0]     walk_ptr;
    word_t                demap_va_q;

    logic                 accept;
    op_kind_e             kind;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    entry_t               wr_ent;
    entry_t               old_ent;
    entry_t               walk_ent;
    logic                 drop;
    logic                 demap_start;
    flush_t               flush_d;
    flush_t               flush_q;
    word_t                old_mask;

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_flags
            assign live_vec[g] = is_live(ent_q[g].tte);
            assign pin_vec[g]  = is_pinned(ent_q[g].tte);
        end
    endgenerate

    tlbm_victim_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
        .live_vec (live_vec),
        .pin_vec  (pin_vec),
        .found_o  (vict_found),
        .idx_o    (vict_idx)
    );

    tlbm_demap_walker #(.N_ENTRIES(N_ENTRIES)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start_i (demap_start),
        .busy_o  (walk_busy),
        .ptr_o   (walk_ptr)
    );

    assign accept   = op_valid && !walk_busy;
    assign kind     = op_kind_e'(op_kind);
    assign walk_ent = ent_q[walk_ptr];

    always_comb begin
        wr_en       = 1'b0;
        wr_idx      = '0;
        wr_ent      = '0;
        drop        = 1'b0;
        demap_start = 1'b0;
        if (walk_busy) begin
            if (is_live(walk_ent.tte) &&
                (((demap_va_q ^ walk_ent.tag) & page_mask(walk_ent.tte)) == '0)) begin
                wr_en  = 1'b1;
                wr_idx = walk_ptr;
            end
        end else if (accept) begin
            unique case (kind)
                OP_MAP: begin
                    if (vict_found) begin
                        wr_en  = 1'b1;
                        wr_idx = vict_idx;
                        wr_ent = '{tag: tag_access_i, tte: op_data};
                    end else begin
                        drop = 1'b1;
                    end
                end
                OP_DIRECT: begin
                    wr_en  = 1'b1;
                    wr_idx = op_addr[IDX_LSB +: IDX_W];
                    wr_ent = '{tag: tag_access_i, tte: op_data};
                end
                OP_DEMAP: demap_start = 1'b1;
                default:  ;
            endcase
        end
    end

    assign old_ent  = ent_q[wr_idx];
    assign old_mask = page_mask(old_ent.tte);

    always_comb begin
        flush_d.valid = wr_en && is_live(old_ent.tte);
        flush_d.base  = old_ent.tag & old_mask;
        flush_d.size  = ~old_mask + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
            demap_va_q <= '0;
            flush_q    <= '0;
            no_slot_o  <= 1'b0;
        end else begin
            if (wr_en) begin
                ent_q[wr_idx] <= wr_ent;
            end
            if (demap_start) begin
                demap_va_q <= op_addr;
            end
            flush_q   <= flush_d.valid ? flush_d : '0;
            no_slot_o <= drop;
        end
    end

    assign rd_tag_o      = ent_q[rd_idx].tag;
    assign rd_tte_o      = ent_q[rd_idx].tte;
    assign busy_o        = walk_busy;
    assign flush_valid_o = flush_q.valid;
    assign flush_base_o  = flush_q.base;
    assign flush_size_o  = flush_q.size;

endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker
    import tlbm_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic              busy_o,
    input logic              no_slot_o,
    input logic              flush_valid_o,
    input logic [WORD_W-1:0] flush_base_o,
    input logic [WORD_W-1:0] flush_size_o
);
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) busy_cnt <= '0;
        else                busy_cnt <= busy_cnt + 1'b1;
    end

    // R1: idle outputs right after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!busy_o && !no_slot_o && !flush_valid_o));

    // R4: a dropped map never flushes
    a_r4_drop_no_flush: assert property (@(posedge clk) disable iff (rst)
        no_slot_o |-> !flush_valid_o);

    // R4: drop only follows an accepted map request
    a_r4_drop_after_map: assert property (@(posedge clk) disable iff (rst)
        $rose(no_slot_o) |-> $past(op_valid && op_kind == 2'd0 && !busy_o));

    // R7: flush size is a power of two and base is aligned to it
    a_r7_flush_shape: assert property (@(posedge clk) disable iff (rst)
        flush_valid_o |-> ($countones(flush_size_o) == 1 &&
                           (flush_base_o & (flush_size_o - 1'b1)) == '0));

    // R8: walk starts only from an accepted demap request
    a_r8_walk_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(op_valid && op_kind == 2'd2));

    // R8: walk lasts exactly one cycle per slot
    a_r8_walk_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> busy_cnt == CNT_W'(N_ENTRIES));

    // R9: no drop reported while walking
    a_r9_busy_no_drop: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> !no_slot_o);

endmodule

bind tlb_maint_engine tlbm_checker #(.N_ENTRIES(N_ENTRIES)) u_tlbm_checker (.*);

// File: tb/test_tlb_maint_engine.sv
module test_tlb_maint_engine;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [63:0] op_addr;
    logic [63:0] op_data;
    logic [63:0] tag_access_i;
    logic [5:0]  rd_idx;
    logic [63:0] rd_tag_o;
    logic [63:0] rd_tte_o;
    logic        busy_o;
    logic        no_slot_o;
    logic        flush_valid_o;
    logic [63:0] flush_base_o;
    logic [63:0] flush_size_o;

    int n_checks = 0;
    int n_fail   = 0;
    int flush_cnt;
    int busy_cycles;
    logic [63:0] last_base;
    logic [63:0] last_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_maint_engine i_tlb_maint_engine (.*);

    always @(negedge clk) begin
        if (flush_valid_o) begin
            flush_cnt <= flush_cnt + 1;
            last_base <= flush_base_o;
            last_size <= flush_size_o;
        end
        if (busy_o) busy_cycles <= busy_cycles + 1;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tte(int sz, bit pin, logic [63:0] pa);
        return 64'h8000_0000_0000_0000 | (64'(sz) << 61) | (64'(pin) << 6) | pa;
    endfunction

    task automatic peek(int idx, output logic [63:0] tag, output logic [63:0] tte);
        rd_idx = 6'(idx);
        #1;
        tag = rd_tag_o;
        tte = rd_tte_o;
    endtask

    task automatic issue(logic [1:0] kind, logic [63:0] addr, logic [63:0] data,
                         logic [63:0] tagv);
        @(negedge clk);
        op_valid     = 1'b1;
        op_kind      = kind;
        op_addr      = addr;
        op_data      = data;
        tag_access_i = tagv;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        op_valid = 1'b0; op_kind = 2'd3; op_addr = '0; op_data = '0;
        tag_access_i = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] tg, tt;
        do_reset();
        check("R1 busy", 64'(busy_o), 0);
        check("R1 no_slot", 64'(no_slot_o), 0);
        check("R1 flush", 64'(flush_valid_o), 0);
        peek(0, tg, tt);  check("R1 slot0 tte", tt, 0);
        peek(63, tg, tt); check("R1 slot63 tag", tg, 0);
    endtask

    task automatic t_replace();
        logic [63:0] tg, tt;
        do_reset();
        // Fill all slots live+pinned, except 10 and 20 unpinned, 40 empty
        for (int i = 0; i < N; i++) begin
            logic [63:0] w;
            w = (i == 40) ? 64'h0 : mk_tte(0, !(i == 10 || i == 20), 64'h0);
            issue(2'd1, 64'(i) << 3, w, 64'(i) << 13);
        end
        // R2: empty slot 40 wins over lower unpinned slot 10
        issue(2'd0, '0, mk_tte(0, 1, 64'h1_0000), 64'hAAAA_0000_0000_0000);
        check("R7 no flush on empty victim", 64'(flush_valid_o), 0);
        peek(40, tg, tt);
        check("R2 slot40 tag", tg, 64'hAAAA_0000_0000_0000);
        check("R6 slot40 tte", tt, mk_tte(0, 1, 64'h1_0000));
        peek(10, tg, tt);
        check("R2 slot10 kept", tg, 64'h1_4000);
        // R3: first unpinned slot 10
        issue(2'd0, '0, mk_tte(2, 1, 64'h0), 64'h500_0000);
        check("R7 flush valid", 64'(flush_valid_o), 1);
        check("R7 flush base", flush_base_o, 64'h1_4000);
        check("R7 flush size", flush_size_o, 64'h2000);
        peek(10, tg, tt);
        check("R3 slot10 tag", tg, 64'h500_0000);
        // R3: next unpinned is 20
        issue(2'd0, '0, mk_tte(0, 1, 64'h0), 64'h600_0000);
        check("R3 flush base slot20", flush_base_o, 64'h2_8000);
        // R4: all pinned, map dropped
        issue(2'd0, '0, mk_tte(0, 0, 64'h0), 64'h700_0000);
        check("R4 no_slot", 64'(no_slot_o), 1);
        check("R4 no flush", 64'(flush_valid_o), 0);
        peek(0, tg, tt);
        check("R4 slot0 tag kept", tg, 64'h0);
        check("R4 slot0 tte kept", tt, mk_tte(0, 1, 64'h0));
        @(negedge clk);
        check("R4 no_slot one cycle", 64'(no_slot_o), 0);
        // R5: direct write over pinned slot 5, size-3 new word
        issue(2'd1, 64'd5 << 3, mk_tte(3, 0, 64'h0), 64'h4000_0000);
        check("R5 flush base slot5", flush_base_o, 64'hA000);
        peek(5, tg, tt);
        check("R5 slot5 tag", tg, 64'h4000_0000);
        check("R5 slot5 tte", tt, mk_tte(3, 0, 64'h0));
        // R7: overwrite size-3 slot, flush 4 MiB page
        issue(2'd1, 64'd5 << 3, 64'h0, 64'h0);
        check("R7 size3 base", flush_base_o, 64'h4000_0000);
        check("R7 size3 size", flush_size_o, 64'h40_0000);
    endtask

    task automatic t_demap();
        logic [63:0] tg, tt;
        logic [63:0] va;
        va = 64'h40_2000;
        do_reset();
        issue(2'd1, 64'd0 << 3,  mk_tte(0, 1, 64'h0), 64'h40_2000);
        issue(2'd1, 64'd1 << 3,  mk_tte(0, 0, 64'h0), 64'h40_4000);
        issue(2'd1, 64'd2 << 3,  mk_tte(1, 0, 64'h0), 64'h40_0000);
        issue(2'd1, 64'd3 << 3,  64'h0000_0000_0000_1234, 64'h40_2000);
        issue(2'd1, 64'd4 << 3,  mk_tte(1, 0, 64'h0), 64'h41_0000);
        issue(2'd1, 64'd63 << 3, mk_tte(0, 0, 64'h0), 64'h40_2000);
        flush_cnt   = 0;
        busy_cycles = 0;
        issue(2'd2, va, '0, '0);
        check("R8 busy after start", 64'(busy_o), 1);
        // R9: direct write while walking is ignored
        issue(2'd1, 64'd7 << 3, mk_tte(0, 0, 64'h0), 64'h77_0000);
        while (busy_o) @(negedge clk);
        #1;
        check("R8 busy length", 64'(busy_cycles), 64);
        check("R7 demap flush count", 64'(flush_cnt), 3);
        check("R7 last flush base", last_base, 64'h40_2000);
        check("R7 last flush size", last_size, 64'h2000);
        peek(0, tg, tt);  check("R8 slot0 cleared", tt, 0);
        peek(1, tg, tt);  check("R8 slot1 kept", tg, 64'h40_4000);
        peek(2, tg, tt);  check("R8 slot2 cleared 64K", tg, 0);
        peek(3, tg, tt);  check("R8 empty slot3 kept", tt, 64'h1234);
        peek(4, tg, tt);  check("R8 slot4 kept", tg, 64'h41_0000);
        peek(63, tg, tt); check("R8 slot63 cleared", tt, 0);
        peek(7, tg, tt);  check("R9 slot7 untouched", tt, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        flush_cnt = 0;
        busy_cycles = 0;
        last_base = '0;
        last_size = '0;
        t_reset();
        t_replace();
        t_demap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule